// File: doc/BRIEF.md
# Zone-Protected Associative Translation Buffer

This block holds a set of page translations and resolves one address lookup per cycle with no clock latency. Each slot records whether it is in use, an effective page base, a real page base, a log2 page size, an owning process tag, a zone number and a three-bit permission set. A lookup presents an effective address, the running process tag, a user/supervisor flag and the kind of access. In the same cycle the block reports whether a slot matched, the translated address, the permissions that apply and a fault class.

The permissions that apply do not always come from the slot. A 32-bit zone control word, supplied from outside, holds a two-bit code for each of sixteen zones. Depending on the zone code and the privilege level, that code can grant everything, defer to the slot's own bits, or refuse a user access outright with a zone fault. When an access faults on permissions or on the zone, the block also requests a write of a syndrome value for the exception logic to capture.

Slots are loaded one per clock through an index/data write port. A separate combinational read port returns any slot for inspection. Table walking and exception sequencing stay outside the block.

Top module: `tlbz_top`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into slot `wr_idx` at the rising clock edge. `rd_data` always shows slot `rd_idx`. Slot word layout: bit 83 in-use, 82:75 process tag, 74:71 zone, 70:68 permissions (bit 68 read, 69 write, 70 execute), 67:64 size code, 63:32 effective page base, 31:0 real page base. Reset clears every slot to all zeros.
- R2: A slot whose in-use bit is clear never matches.
- R3: A slot with process tag 0 matches any `lk_pid`. Any other slot tag must equal `lk_pid`.
- R4: Size code c gives a page of 2^(10+c) bytes. Codes above 14 act as 14 (16 MB). A slot matches only when the effective address, with the page-offset bits cleared, equals the slot's effective page base.
- R5: On a hit, `lk_pa` is the real page base with the page-offset bits cleared, ORed with the page-offset bits of the effective address.
- R6: When several slots match, the highest-numbered matching slot decides every output.
- R7: The zone code for zone z is `zpr[31-2z:30-2z]`. Code 3 grants read, write and execute (`lk_prot`=7) at both privilege levels.
- R8: Code 2 grants 7 to supervisor accesses (`lk_user`=0). User accesses fall back to the slot's own permission bits.
- R9: Code 1 at either level, and code 0 in supervisor mode, use the slot's own bits. Access type is 0 load, 1 store, 2 fetch, with 3 treated as load. A load needs read, a store needs write and a fetch needs execute.
- R10: Code 0 on a user access gives `lk_fault`=2 (zone fault) and `lk_prot`=0, and asserts `syn_we` with `syn_val`=32'h0040_0000 (bit 22 set).
- R11: When the slot's bits deny the access, the block gives `lk_fault`=3 (permission fault) and `lk_prot` equal to the slot's bits, and asserts `syn_we` with `syn_val`=0.
- R12: With no matching slot, `lk_hit`=0, `lk_fault`=1, and `lk_pa`, `lk_prot` and `syn_we` are all 0. A granted hit gives `lk_fault`=0 and `syn_we`=0. `syn_val` is 0 whenever `syn_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot to write |
| wr_data | input | 84 | Slot word to store |
| rd_idx | input | 6 | Slot to read back |
| rd_data | output | 84 | Slot word at `rd_idx` |
| zpr | input | 32 | Zone control word, 2 bits per zone |
| lk_ea | input | 32 | Effective address of the lookup |
| lk_pid | input | 8 | Running process tag |
| lk_user | input | 1 | 1 = user access, 0 = supervisor |
| lk_acc | input | 2 | Access type |
| lk_hit | output | 1 | A slot matched |
| lk_pa | output | 32 | Translated address |
| lk_prot | output | 3 | Permissions that apply |
| lk_fault | output | 2 | 0 none, 1 miss, 2 zone, 3 permission |
| syn_we | output | 1 | Syndrome write request |
| syn_val | output | 32 | Syndrome value |

## Verification
Some properties are checked on every cycle. A miss stays silent, and a zone fault occurs only for a user access to a code-0 zone, with the bit-22 syndrome. A permission fault reports the selected slot's bits with a zero syndrome. Zone code 3, and code 2 in supervisor mode, always yield full rights, the low ten address bits always pass straight through, and a write shows up on the read port one cycle later. Some behaviours only the scenarios can show: tag wildcarding, page-size masking including the clamp of oversized codes, highest-slot priority between overlapping slots, in-use gating, and clearing on reset.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;
   localparam int AW   = 32;
   localparam int PIDW = 8;
   localparam int ZW   = 4;
   localparam int SZW  = 4;

   typedef struct packed {
      logic            v;
      logic [PIDW-1:0] pid;
      logic [ZW-1:0]   zone;
      logic [2:0]      perm;   // bit0 read, bit1 write, bit2 execute
      logic [SZW-1:0]  sz;
      logic [AW-1:0]   epn;
      logic [AW-1:0]   rpn;
   } ent_t;

   localparam int ENT_W = $bits(ent_t);

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_MISS = 2'd1,
      FLT_ZONE = 2'd2,
      FLT_PERM = 2'd3
   } flt_e;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   localparam logic [31:0] ZONE_SYN = 32'h0040_0000;
endpackage

// File: rtl/tlbz_store.sv
module tlbz_store #(
   parameter int N_ENT = 64,
   localparam int IW   = $clog2(N_ENT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IW-1:0]              wr_idx,
   input  logic [tlbz_pkg::ENT_W-1:0] wr_data,
   input  logic [IW-1:0]              rd_idx,
   output logic [tlbz_pkg::ENT_W-1:0] rd_data,
   output tlbz_pkg::ent_t             ents [N_ENT]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
      end else if (wr_en) begin
         ents[wr_idx] <= tlbz_pkg::ent_t'(wr_data);
      end
   end

   assign rd_data = ents[rd_idx];
endmodule

// File: rtl/tlbz_match.sv
module tlbz_match #(
   parameter int N_ENT     = 64,
   parameter int MIN_PG_LG = 10,
   parameter int MAX_SZ    = 14,
   localparam int IW       = $clog2(N_ENT),
   localparam int AW       = tlbz_pkg::AW
) (
   input  tlbz_pkg::ent_t               ents [N_ENT],
   input  logic [AW-1:0]                ea,
   input  logic [tlbz_pkg::PIDW-1:0]    pid,
   output logic                         hit,
   output logic [IW-1:0]                idx,
   output logic [AW-1:0]                pa
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic          m    [N_ENT];
   logic [AW-1:0] pa_g [N_ENT];

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic [tlbz_pkg::SZW-1:0] szc;
      logic [AW-1:0]            mask;
      logic                     pid_ok;
      always_comb begin
         szc    = (ents[g].sz > tlbz_pkg::SZW'(MAX_SZ)) ? tlbz_pkg::SZW'(MAX_SZ) : ents[g].sz;
         mask   = ~((ONE << (MIN_PG_LG + int'(szc))) - ONE);
         pid_ok = (ents[g].pid == '0) || (ents[g].pid == pid);
         m[g]   = ents[g].v && pid_ok && ((ea & mask) == ents[g].epn);
         pa_g[g] = (ents[g].rpn & mask) | (ea & ~mask);
      end
   end

   // later slots overwrite earlier ones: highest index wins
   always_comb begin
      hit = 1'b0;
      idx = '0;
      pa  = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (m[i]) begin
            hit = 1'b1;
            idx = IW'(i);
            pa  = pa_g[i];
         end
      end
   end
endmodule

// File: rtl/tlbz_zone.sv
module tlbz_zone (
   input  logic                     hit,
   input  logic [2:0]               perm,
   input  logic [tlbz_pkg::ZW-1:0]  zone,
   input  logic [31:0]              zpr,
   input  logic                     user,
   input  logic [1:0]               acc,
   output logic [1:0]               zcode,
   output logic [2:0]               prot,
   output tlbz_pkg::flt_e           fault,
   output logic                     syn_we,
   output logic [31:0]              syn_val
);
   import tlbz_pkg::*;

   logic [4:0]  sh;
   logic [31:0] zsh;
   logic [2:0]  need;
   logic        own_ok;

   always_comb begin
      sh    = 5'd30 - {zone, 1'b0};
      zsh   = zpr >> sh;
      zcode = zsh[1:0];
      unique case (acc)
         ACC_STORE: need = 3'b010;
         ACC_FETCH: need = 3'b100;
         default:   need = 3'b001;
      endcase
      own_ok = |(perm & need);

      prot  = perm;
      fault = own_ok ? FLT_NONE : FLT_PERM;
      unique case (zcode)
         2'd3: begin
            prot  = 3'b111;
            fault = FLT_NONE;
         end
         2'd2: if (!user) begin
            prot  = 3'b111;
            fault = FLT_NONE;
         end
         2'd0: if (user) begin
            prot  = 3'b000;
            fault = FLT_ZONE;
         end
         default: ;
      endcase
      if (!hit) begin
         prot  = 3'b000;
         fault = FLT_MISS;
      end

      syn_we  = (fault == FLT_ZONE) || (fault == FLT_PERM);
      syn_val = (fault == FLT_ZONE) ? ZONE_SYN : 32'd0;
   end
endmodule

// File: rtl/tlbz_top.sv
module tlbz_top #(
   parameter int N_ENT     = 64,
   parameter int MIN_PG_LG = 10,
   parameter int MAX_SZ    = 14,
   localparam int IW       = $clog2(N_ENT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IW-1:0]              wr_idx,
   input  logic [tlbz_pkg::ENT_W-1:0] wr_data,
   input  logic [IW-1:0]              rd_idx,
   output logic [tlbz_pkg::ENT_W-1:0] rd_data,
   input  logic [31:0]                zpr,
   input  logic [tlbz_pkg::AW-1:0]    lk_ea,
   input  logic [tlbz_pkg::PIDW-1:0]  lk_pid,
   input  logic                       lk_user,
   input  logic [1:0]                 lk_acc,
   output logic                       lk_hit,
   output logic [tlbz_pkg::AW-1:0]    lk_pa,
   output logic [2:0]                 lk_prot,
   output logic [1:0]                 lk_fault,
   output logic                       syn_we,
   output logic [31:0]                syn_val
);
   if (N_ENT < 2) begin : g_bad_n
      $error("tlbz_top: N_ENT must be at least 2");
   end
   if (MIN_PG_LG + MAX_SZ >= tlbz_pkg::AW) begin : g_bad_pg
      $error("tlbz_top: largest page does not fit the address width");
   end
   if (MAX_SZ > (1 << tlbz_pkg::SZW) - 1) begin : g_bad_sz
      $error("tlbz_top: MAX_SZ exceeds the size code range");
   end

   tlbz_pkg::ent_t ents [N_ENT];
   tlbz_pkg::ent_t sel_ent;
   tlbz_pkg::flt_e fault;
   logic [IW-1:0]  sel_idx;
   logic [1:0]     sel_zcode;

   tlbz_store #(.N_ENT(N_ENT)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .ents    (ents)
   );

   tlbz_match #(.N_ENT(N_ENT), .MIN_PG_LG(MIN_PG_LG), .MAX_SZ(MAX_SZ)) u_match (
      .ents (ents),
      .ea   (lk_ea),
      .pid  (lk_pid),
      .hit  (lk_hit),
      .idx  (sel_idx),
      .pa   (lk_pa)
   );

   assign sel_ent = ents[sel_idx];

   tlbz_zone u_zone (
      .hit     (lk_hit),
      .perm    (sel_ent.perm),
      .zone    (sel_ent.zone),
      .zpr     (zpr),
      .user    (lk_user),
      .acc     (lk_acc),
      .zcode   (sel_zcode),
      .prot    (lk_prot),
      .fault   (fault),
      .syn_we  (syn_we),
      .syn_val (syn_val)
   );

   assign lk_fault = fault;
endmodule

// File: rtl/tlbz_chk.sv
module tlbz_chk #(
   parameter int N_ENT = 64,
   localparam int IW   = $clog2(N_ENT)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [IW-1:0]              wr_idx,
   input logic [tlbz_pkg::ENT_W-1:0] wr_data,
   input logic [IW-1:0]              rd_idx,
   input logic [tlbz_pkg::ENT_W-1:0] rd_data,
   input logic [31:0]                lk_ea,
   input logic                       lk_user,
   input logic                       lk_hit,
   input logic [31:0]                lk_pa,
   input logic [2:0]                 lk_prot,
   input logic [1:0]                 lk_fault,
   input logic                       syn_we,
   input logic [31:0]                syn_val,
   input logic [1:0]                 zcode,
   input logic [2:0]                 eperm
);
   AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && rd_idx == $past(wr_idx)) |-> rd_data == $past(wr_data)); // R1

   AST_PA_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_pa[9:0] == lk_ea[9:0]); // R5

   AST_ZONE3_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && zcode == 2'd3) |-> (lk_prot == 3'b111 && lk_fault == 2'd0)); // R7

   AST_ZONE2_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && zcode == 2'd2 && !lk_user) |-> (lk_prot == 3'b111 && lk_fault == 2'd0)); // R8

   AST_ZONE_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault == 2'd2) |-> (lk_user && zcode == 2'd0 && lk_prot == 3'b000
                              && syn_we && syn_val == 32'h0040_0000)); // R10

   AST_PERM_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault == 2'd3) |-> (lk_prot == eperm && syn_we && syn_val == 32'd0)); // R11

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault == 2'd1) |-> (!lk_hit && lk_pa == 32'd0 && lk_prot == 3'b000 && !syn_we)); // R12

   AST_HIT_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_fault != 2'd1)); // R12
endmodule

bind tlbz_top tlbz_chk #(.N_ENT(N_ENT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data),
   .rd_idx   (rd_idx),
   .rd_data  (rd_data),
   .lk_ea    (lk_ea),
   .lk_user  (lk_user),
   .lk_hit   (lk_hit),
   .lk_pa    (lk_pa),
   .lk_prot  (lk_prot),
   .lk_fault (lk_fault),
   .syn_we   (syn_we),
   .syn_val  (syn_val),
   .zcode    (sel_zcode),
   .eperm    (sel_ent.perm)
);

// File: tb/tb_tlbz_top.sv
module tb_tlbz_top;
   localparam int CLK_P = 10;
   localparam logic [31:0] ZA = 32'h1B00_0000; // zones 0..3 -> codes 0,1,2,3
   localparam logic [31:0] ZB = 32'hDB00_0000; // zone 0 -> code 3

   typedef struct packed {
      logic [31:0] ea;
      logic [7:0]  pid;
      logic        user;
      logic [1:0]  acc;
      logic [31:0] zpr;
      logic        hit;
      logic [31:0] pa;
      logic [2:0]  prot;
      logic [1:0]  fault;
      logic [3:0]  req;
   } vec_t;

   // columns: ea, pid, user, acc, zpr | hit, pa, prot, fault | requirement
   localparam vec_t VECS [17] = '{
      '{32'h0000_1234, 8'd7, 1'b0, 2'd0, ZA, 1'b1, 32'h8000_0234, 3'd1, 2'd0, 4'd9 },  // R9 code0 super, R3 wildcard
      '{32'h0000_1234, 8'd7, 1'b1, 2'd0, ZA, 1'b1, 32'h8000_0234, 3'd0, 2'd2, 4'd10},  // R10
      '{32'h0000_1234, 8'd7, 1'b0, 2'd1, ZA, 1'b1, 32'h8000_0234, 3'd1, 2'd3, 4'd11},  // R11
      '{32'h0000_1234, 8'd7, 1'b1, 2'd0, ZB, 1'b1, 32'h8000_0234, 3'd7, 2'd0, 4'd7 },  // R7
      '{32'h0000_2010, 8'd5, 1'b1, 2'd1, ZA, 1'b1, 32'h9000_0410, 3'd3, 2'd0, 4'd5 },  // R5 R9 code1
      '{32'h0000_2010, 8'd6, 1'b1, 2'd1, ZA, 1'b0, 32'h0000_0000, 3'd0, 2'd1, 4'd3 },  // R3 mismatch
      '{32'h0000_2010, 8'd5, 1'b1, 2'd2, ZA, 1'b1, 32'h9000_0410, 3'd3, 2'd3, 4'd11},  // R11 fetch
      '{32'h10AB_CDEF, 8'd9, 1'b0, 2'd1, ZA, 1'b1, 32'h23AB_CDEF, 3'd7, 2'd0, 4'd8 },  // R8 super
      '{32'h10AB_CDEF, 8'd9, 1'b1, 2'd1, ZA, 1'b1, 32'h23AB_CDEF, 3'd4, 2'd3, 4'd8 },  // R8 user
      '{32'h10AB_CDEF, 8'd9, 1'b1, 2'd2, ZA, 1'b1, 32'h23AB_CDEF, 3'd4, 2'd0, 4'd8 },  // R8 user fetch
      '{32'h0000_3001, 8'd0, 1'b1, 2'd1, ZA, 1'b1, 32'h0000_7001, 3'd7, 2'd0, 4'd7 },  // R7
      '{32'h0000_5000, 8'd0, 1'b0, 2'd0, ZA, 1'b0, 32'h0000_0000, 3'd0, 2'd1, 4'd2 },  // R2
      '{32'h0000_6ABC, 8'd0, 1'b0, 2'd1, ZA, 1'b1, 32'h5000_0ABC, 3'd2, 2'd0, 4'd6 },  // R6
      '{32'h0000_6ABC, 8'd0, 1'b0, 2'd0, ZA, 1'b1, 32'h5000_0ABC, 3'd2, 2'd3, 4'd6 },  // R6
      '{32'h0000_1234, 8'd7, 1'b0, 2'd3, ZA, 1'b1, 32'h8000_0234, 3'd1, 2'd0, 4'd9 },  // R9 type 3 as load
      '{32'h0000_2410, 8'd5, 1'b0, 2'd0, ZA, 1'b0, 32'h0000_0000, 3'd0, 2'd1, 4'd4 },  // R4 1KB boundary
      '{32'h30FF_FFFF, 8'd0, 1'b0, 2'd0, ZA, 1'b1, 32'h45FF_FFFF, 3'd7, 2'd0, 4'd4 }   // R4 clamp
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [83:0] wr_data = '0;
   logic [5:0]  rd_idx = '0;
   logic [83:0] rd_data;
   logic [31:0] zpr = ZA;
   logic [31:0] lk_ea = '0;
   logic [7:0]  lk_pid = '0;
   logic        lk_user = 1'b0;
   logic [1:0]  lk_acc = '0;
   logic        lk_hit;
   logic [31:0] lk_pa;
   logic [2:0]  lk_prot;
   logic [1:0]  lk_fault;
   logic        syn_we;
   logic [31:0] syn_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tlbz_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .zpr(zpr), .lk_ea(lk_ea), .lk_pid(lk_pid),
      .lk_user(lk_user), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_pa(lk_pa),
      .lk_prot(lk_prot), .lk_fault(lk_fault), .syn_we(syn_we), .syn_val(syn_val)
   );

   function automatic logic [83:0] mk(logic v, logic [7:0] pid, logic [3:0] zone,
                                      logic [2:0] perm, logic [3:0] sz,
                                      logic [31:0] epn, logic [31:0] rpn);
      return {v, pid, zone, perm, sz, epn, rpn};
   endfunction

   task automatic put(input logic [5:0] idx, input logic [83:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic look(input vec_t v);
      logic [31:0] esv;
      @(negedge clk);
      lk_ea = v.ea; lk_pid = v.pid; lk_user = v.user; lk_acc = v.acc; zpr = v.zpr;
      #1;
      esv = (v.fault == 2'd2) ? 32'h0040_0000 : 32'd0;
      chk($sformatf("R%0d lookup ea=%h", v.req, v.ea),
          {lk_hit, lk_pa, lk_prot, lk_fault, syn_we, syn_val},
          {v.hit, v.pa, v.prot, v.fault, (v.fault >= 2'd2), esv});
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_idx = 6'd0; #1;
      chk("R1 reset readback", 128'(rd_data), 128'd0);
      look('{32'h0000_0000, 8'd0, 1'b0, 2'd0, ZA, 1'b0, 32'd0, 3'd0, 2'd1, 4'd12}); // R12 empty miss

      put(6'd0,  mk(1'b1, 8'd0, 4'd0, 3'd1, 4'd2,  32'h0000_1000, 32'h8000_0000));
      put(6'd1,  mk(1'b1, 8'd5, 4'd1, 3'd3, 4'd0,  32'h0000_2000, 32'h9000_0400));
      put(6'd2,  mk(1'b1, 8'd0, 4'd2, 3'd4, 4'd14, 32'h1000_0000, 32'h2300_0000));
      put(6'd3,  mk(1'b1, 8'd0, 4'd3, 3'd0, 4'd0,  32'h0000_3000, 32'h0000_7000));
      put(6'd5,  mk(1'b0, 8'd0, 4'd3, 3'd7, 4'd2,  32'h0000_5000, 32'h6000_0000));
      put(6'd10, mk(1'b1, 8'd0, 4'd1, 3'd1, 4'd2,  32'h0000_6000, 32'h4000_0000));
      put(6'd20, mk(1'b1, 8'd0, 4'd1, 3'd2, 4'd2,  32'h0000_6000, 32'h5000_0000));
      put(6'd30, mk(1'b1, 8'd0, 4'd3, 3'd0, 4'd15, 32'h3000_0000, 32'h4500_0000));

      for (int i = 0; i < 17; i++) look(VECS[i]);

      // R1 readback of written slots
      rd_idx = 6'd1; #1;
      chk("R1 readback slot1", 128'(rd_data),
          128'(mk(1'b1, 8'd5, 4'd1, 3'd3, 4'd0, 32'h0000_2000, 32'h9000_0400)));
      rd_idx = 6'd30; #1;
      chk("R1 readback slot30", 128'(rd_data),
          128'(mk(1'b1, 8'd0, 4'd3, 3'd0, 4'd15, 32'h3000_0000, 32'h4500_0000)));

      // R6 overwrite highest slot invalid: lower slot now decides
      put(6'd20, mk(1'b0, 8'd0, 4'd1, 3'd2, 4'd2, 32'h0000_6000, 32'h5000_0000));
      look('{32'h0000_6ABC, 8'd0, 1'b0, 2'd0, ZA, 1'b1, 32'h4000_0ABC, 3'd1, 2'd0, 4'd6}); // R6 R2

      // R1 reset clears contents
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_idx = 6'd2; #1;
      chk("R1 cleared after reset", 128'(rd_data), 128'd0);
      look('{32'h10AB_CDEF, 8'd9, 1'b0, 2'd1, ZA, 1'b0, 32'd0, 3'd0, 2'd1, 4'd12}); // R12

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule